// File: doc/BRIEF.md
# DMA Page Mapping and Channel Scheduler

This block sits next to a pair of cascaded four-channel DMA controllers and holds everything needed to turn a channel's 16-bit current address into a full physical address. It keeps an 8-bit low page register and an optional 8-bit high page register for each of the eight channels. Software reaches these registers through a sparse I/O port map, in which only four offsets inside each eight-port window are populated.

Every cycle the scheduler looks at the eight channels. A channel is runnable when peripherals have raised its request and its mask bit is clear. The scheduler picks one runnable channel with a rotating search and issues a registered grant. The grant carries:
- the global channel number,
- the physical address, built from the high page, the low page and the current address,
- the direction taken from the channel's mode byte,
- the transfer length in bytes, which is doubled on the second controller because that controller moves 16-bit words,
- a flag that marks runs whose mode cannot be serviced.

Peripherals raise and drop requests through hold and release strobes.

Top module: `dma_page_sched`

## Requirements
- R1: Within each page window, port offset 1 selects local channel 2, offset 2 selects channel 3, offset 3 selects channel 1 and offset 7 selects channel 0. Port address bit 3 picks the controller, which adds 4 to the channel number. A write to offset 0, 4, 5 or 6 of a window changes no register and raises `pg_err` for exactly one cycle after the write edge. A read of such an offset returns 0.
- R2: The low page windows are at 0x080–0x087 (controller 0) and 0x088–0x08F (controller 1). The high page windows are at 0x480–0x487 and 0x488–0x48F and are decoded only when `HIGH_PAGE_EN` is 1. Otherwise, writes to them have no effect, raise no error and read back as 0. `pg_rd_data` combinationally returns the register addressed by `pg_rd_addr`.
- R3: The granted address is {high_page[6:0], low_page[7:0], current_address[15:0]}, so bit 7 of the high page never appears.
- R4: A channel is eligible when its bit in `mask_i` is 0 and its request bit is 1. If no channel is eligible, `grant_o` stays low.
- R5: The search order is channel 0 through 7, where channels 0–3 belong to controller 0. The search starts at the pointer. The pointer is 0 after reset and moves to one past the winner, wrapping from 7 to 0, after each grant.
- R6: `grant_len_o` = (base_count + 1) << controller, where controller = channel bit 2. The count is 18 bits wide, so a base count of 0xFFFF on channel 7 gives 0x20000.
- R7: A `hold_en` strobe sets the request bit of `hold_chan`, and a `rel_en` strobe clears the request bit of `rel_chan`. If both strobes name the same channel in the same cycle, the release wins. A grant does not clear a request.
- R8: `grant_dir_o` is bit 5 of the channel's mode byte. `grant_unsup_o` is 1 when that bit is set or when mode bits 7:6 differ from 01 (single transfer).
- R9: A hold sampled at clock edge k makes the request visible at edge k+1, where it can win and drive `grant_o` high. `grant_o` is high for every cycle in which an eligible channel was found.
- R10: After reset, every page register, every request bit, `grant_o` and `pg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_wr_en | input | 1 | Page port write strobe |
| pg_wr_addr | input | 12 | Page port write address |
| pg_wr_data | input | 8 | Page port write data |
| pg_rd_addr | input | 12 | Page port read address |
| pg_rd_data | output | 8 | Page port read data, combinational |
| pg_err | output | 1 | One-cycle pulse after a write to an unpopulated page offset |
| hold_en | input | 1 | Raise a request |
| hold_chan | input | 3 | Global channel for the hold |
| rel_en | input | 1 | Drop a request |
| rel_chan | input | 3 | Global channel for the release |
| mask_i | input | 8 | Per-channel mask, where 1 blocks the channel |
| mode_i | input | 64 | Mode byte per channel; channel c occupies bits 8c+7:8c |
| cur_addr_i | input | 8*CUR_W | Current address per channel |
| base_cnt_i | input | 8*CNT_W | Base count per channel |
| grant_o | output | 1 | Grant issued this cycle |
| grant_chan_o | output | 3 | Granted global channel |
| grant_addr_o | output | 15+CUR_W | Physical address of the granted channel |
| grant_dir_o | output | 1 | Direction bit of the granted channel |
| grant_len_o | output | CNT_W+2 | Transfer length in bytes |
| grant_unsup_o | output | 1 | The granted channel's mode cannot be serviced |

## Verification
The bench goes after the irregular offset-to-channel table. A design that decoded offsets in linear order would fill the wrong page, and the model would see the wrong address on the grant. It writes unpopulated offsets in both controllers' windows and reads every populated port back, so a decode that aliased them would corrupt a neighbour's page or miss the error pulse. It raises all eight requests at once, so a fixed-priority design would starve the upper channels, and a pointer that did not wrap would stall after channel 7. It also drives a hold and a release on the same channel in the same cycle, sets channel 7's base count to the maximum so that a truncated length would drop its top bit, and sets bit 7 in every high page, which must not leak into the address.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    localparam int NCH      = 8;
    localparam int CH_W     = 3;
    localparam int PG_W     = 8;
    localparam int HP_USE_W = 7;
    localparam int PORT_W   = 12;
    localparam int MODE_W   = 8;

    localparam logic [7:0] LOW_WIN  = 8'h08;
    localparam logic [7:0] HIGH_WIN = 8'h48;

    typedef struct packed {
        logic            hit;
        logic            high;
        logic            valid;
        logic [CH_W-1:0] chan;
    } pg_dec_t;

    function automatic pg_dec_t pg_decode(input logic [PORT_W-1:0] a, input logic hp_en);
        pg_dec_t r;
        r = '0;
        if (a[11:4] == LOW_WIN) begin
            r.hit = 1'b1;
        end else if (hp_en && a[11:4] == HIGH_WIN) begin
            r.hit  = 1'b1;
            r.high = 1'b1;
        end
        r.chan[2] = a[3];
        unique case (a[2:0])
            3'd1:    begin r.chan[1:0] = 2'd2; r.valid = r.hit; end
            3'd2:    begin r.chan[1:0] = 2'd3; r.valid = r.hit; end
            3'd3:    begin r.chan[1:0] = 2'd1; r.valid = r.hit; end
            3'd7:    begin r.chan[1:0] = 2'd0; r.valid = r.hit; end
            default: begin r.chan[1:0] = 2'd0; r.valid = 1'b0;  end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_pg_regfile.sv
module dma_pg_regfile
    import dma_sched_pkg::*;
#(
    parameter bit HP_EN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PORT_W-1:0]      wr_addr,
    input  logic [PG_W-1:0]        wr_data,
    input  logic [PORT_W-1:0]      rd_addr,
    output logic [PG_W-1:0]        rd_data,
    output logic                   acc_err,
    output logic [NCH*PG_W-1:0]    page_o,
    output logic [NCH*PG_W-1:0]    hpage_o
);

    typedef struct packed {
        logic [NCH-1:0][PG_W-1:0] pg;
        logic [NCH-1:0][PG_W-1:0] hp;
        logic                     err;
    } rf_t;

    rf_t     rf_d, rf_q;
    pg_dec_t wdec, rdec;

    always_comb begin
        rf_d     = rf_q;
        rf_d.err = 1'b0;
        wdec     = pg_decode(wr_addr, HP_EN);
        if (wr_en && wdec.hit) begin
            if (!wdec.valid) begin
                rf_d.err = 1'b1;
            end else if (wdec.high) begin
                rf_d.hp[wdec.chan] = wr_data;
            end else begin
                rf_d.pg[wdec.chan] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        rdec = pg_decode(rd_addr, HP_EN);
        if (!rdec.valid)    rd_data = '0;
        else if (rdec.high) rd_data = rf_q.hp[rdec.chan];
        else                rd_data = rf_q.pg[rdec.chan];
    end

    assign acc_err = rf_q.err;
    assign page_o  = rf_q.pg;
    assign hpage_o = rf_q.hp;

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(wr_en)); // R1

    AST_ERR_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> (!acc_err || $past(wr_en))); // R1

endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick
    import dma_sched_pkg::*;
(
    input  logic [NCH-1:0]  elig,
    input  logic [CH_W-1:0] ptr,
    output logic            found,
    output logic [CH_W-1:0] win
);

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NCH; i++) begin
            int idx;
            idx = (int'(ptr) + i) % NCH;
            if (!found && elig[idx]) begin
                found = 1'b1;
                win   = CH_W'(idx);
            end
        end
    end

    AST_WIN_IS_ELIGIBLE: assert final (!found || elig[win]); // R4
    AST_NONE_MEANS_IDLE: assert final (found || elig == '0); // R4

endmodule

// File: rtl/dma_page_sched.sv
module dma_page_sched
    import dma_sched_pkg::*;
#(
    parameter bit HIGH_PAGE_EN = 1'b1,
    parameter int CUR_W        = 16,
    parameter int CNT_W        = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pg_wr_en,
    input  logic [PORT_W-1:0]             pg_wr_addr,
    input  logic [PG_W-1:0]               pg_wr_data,
    input  logic [PORT_W-1:0]             pg_rd_addr,
    output logic [PG_W-1:0]               pg_rd_data,
    output logic                          pg_err,
    input  logic                          hold_en,
    input  logic [CH_W-1:0]               hold_chan,
    input  logic                          rel_en,
    input  logic [CH_W-1:0]               rel_chan,
    input  logic [NCH-1:0]                mask_i,
    input  logic [NCH*MODE_W-1:0]         mode_i,
    input  logic [NCH*CUR_W-1:0]          cur_addr_i,
    input  logic [NCH*CNT_W-1:0]          base_cnt_i,
    output logic                          grant_o,
    output logic [CH_W-1:0]               grant_chan_o,
    output logic [HP_USE_W+PG_W+CUR_W-1:0] grant_addr_o,
    output logic                          grant_dir_o,
    output logic [CNT_W+1:0]              grant_len_o,
    output logic                          grant_unsup_o
);

    localparam int ADDR_W = HP_USE_W + PG_W + CUR_W;
    localparam int LEN_W  = CNT_W + 2;
    localparam logic [1:0] SINGLE_XFER = 2'b01;

    typedef struct packed {
        logic [NCH-1:0]    req;
        logic [CH_W-1:0]   ptr;
        logic              gnt;
        logic [CH_W-1:0]   gchan;
        logic [ADDR_W-1:0] gaddr;
        logic              gdir;
        logic [LEN_W-1:0]  glen;
        logic              gunsup;
    } sch_t;

    sch_t                 s_d, s_q;
    logic [NCH*PG_W-1:0]  page_flat, hpage_flat;
    logic [NCH-1:0]       elig;
    logic                 found;
    logic [CH_W-1:0]      win;
    logic [MODE_W-1:0]    win_mode;
    logic [LEN_W-1:0]     win_len;

    dma_pg_regfile #(.HP_EN(HIGH_PAGE_EN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pg_wr_en),
        .wr_addr (pg_wr_addr),
        .wr_data (pg_wr_data),
        .rd_addr (pg_rd_addr),
        .rd_data (pg_rd_data),
        .acc_err (pg_err),
        .page_o  (page_flat),
        .hpage_o (hpage_flat)
    );

    assign elig = s_q.req & ~mask_i;

    dma_rr_pick u_pick (
        .elig  (elig),
        .ptr   (s_q.ptr),
        .found (found),
        .win   (win)
    );

    always_comb begin
        s_d      = s_q;
        win_mode = mode_i[win*MODE_W +: MODE_W];
        win_len  = LEN_W'(base_cnt_i[win*CNT_W +: CNT_W]) + LEN_W'(1);
        win_len  = win_len << win[CH_W-1];

        if (hold_en) s_d.req[hold_chan] = 1'b1;
        if (rel_en)  s_d.req[rel_chan]  = 1'b0;

        s_d.gnt = found;
        if (found) begin
            s_d.gchan  = win;
            s_d.ptr    = (win == CH_W'(NCH-1)) ? '0 : win + CH_W'(1);
            s_d.gaddr  = {hpage_flat[win*PG_W +: HP_USE_W],
                          page_flat[win*PG_W +: PG_W],
                          cur_addr_i[win*CUR_W +: CUR_W]};
            s_d.gdir   = win_mode[5];
            s_d.glen   = win_len;
            s_d.gunsup = win_mode[5] | (win_mode[7:6] != SINGLE_XFER);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign grant_o       = s_q.gnt;
    assign grant_chan_o  = s_q.gchan;
    assign grant_addr_o  = s_q.gaddr;
    assign grant_dir_o   = s_q.gdir;
    assign grant_len_o   = s_q.glen;
    assign grant_unsup_o = s_q.gunsup;

    AST_GNT_WAS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> |($past(elig) & (NCH'(1) << grant_chan_o))); // R4

    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|elig) |-> !grant_o); // R9

    AST_HOLD_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && !(rel_en && rel_chan == hold_chan)) |=> s_q.req[$past(hold_chan)]); // R7

    AST_REL_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |=> !s_q.req[$past(rel_chan)]); // R7

    AST_CTRL1_LEN_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && grant_chan_o[CH_W-1]) |-> !grant_len_o[0]); // R6

    AST_DIR_IS_UNSUP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && grant_dir_o) |-> grant_unsup_o); // R8

endmodule

// File: tb/dma_page_sched_tb.sv
module dma_page_sched_tb_top;

    localparam int CUR_W = 16;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic        gnt;
        logic [2:0]  chan;
        logic [30:0] addr;
        logic [17:0] len;
        logic        dir;
        logic        unsup;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pg_wr_en = 1'b0;
    logic [11:0]  pg_wr_addr = '0;
    logic [7:0]   pg_wr_data = '0;
    logic [11:0]  pg_rd_addr = '0;
    logic [7:0]   pg_rd_data, nh_rd_data;
    logic         pg_err, nh_err;
    logic         hold_en = 1'b0, rel_en = 1'b0;
    logic [2:0]   hold_chan = '0, rel_chan = '0;
    logic [7:0]   mask_i = '0;
    logic [63:0]  mode_i;
    logic [127:0] cur_addr_i, base_cnt_i;
    logic         grant_o, grant_dir_o, grant_unsup_o;
    logic [2:0]   grant_chan_o;
    logic [30:0]  grant_addr_o;
    logic [17:0]  grant_len_o;
    logic         nh_g, nh_d, nh_u;
    logic [2:0]   nh_c;
    logic [30:0]  nh_a;
    logic [17:0]  nh_l;

    logic [7:0]   pg [8];
    logic [7:0]   hp [8];
    logic [7:0]   mreq;
    logic [2:0]   mptr;
    exp_t         sb_q[$];
    int           n_chk = 0, n_fail = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    dma_page_sched #(.HIGH_PAGE_EN(1'b1), .CUR_W(CUR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pg_wr_en(pg_wr_en), .pg_wr_addr(pg_wr_addr),
        .pg_wr_data(pg_wr_data), .pg_rd_addr(pg_rd_addr), .pg_rd_data(pg_rd_data),
        .pg_err(pg_err), .hold_en(hold_en), .hold_chan(hold_chan), .rel_en(rel_en),
        .rel_chan(rel_chan), .mask_i(mask_i), .mode_i(mode_i), .cur_addr_i(cur_addr_i),
        .base_cnt_i(base_cnt_i), .grant_o(grant_o), .grant_chan_o(grant_chan_o),
        .grant_addr_o(grant_addr_o), .grant_dir_o(grant_dir_o), .grant_len_o(grant_len_o),
        .grant_unsup_o(grant_unsup_o));

    dma_page_sched #(.HIGH_PAGE_EN(1'b0), .CUR_W(CUR_W), .CNT_W(CNT_W)) dut_nohp (
        .clk(clk), .rst_n(rst_n), .pg_wr_en(pg_wr_en), .pg_wr_addr(pg_wr_addr),
        .pg_wr_data(pg_wr_data), .pg_rd_addr(pg_rd_addr), .pg_rd_data(nh_rd_data),
        .pg_err(nh_err), .hold_en(1'b0), .hold_chan(3'd0), .rel_en(1'b0),
        .rel_chan(3'd0), .mask_i(8'd0), .mode_i(64'd0), .cur_addr_i(128'd0),
        .base_cnt_i(128'd0), .grant_o(nh_g), .grant_chan_o(nh_c),
        .grant_addr_o(nh_a), .grant_dir_o(nh_d), .grant_len_o(nh_l),
        .grant_unsup_o(nh_u));

    // R1 table inverted: channel -> port offset inside its window
    function automatic logic [11:0] port_of(input int c, input bit high);
        logic [2:0] off;
        case (c % 4)
            0: off = 3'd7;
            1: off = 3'd3;
            2: off = 3'd1;
            default: off = 3'd2;
        endcase
        return (high ? 12'h480 : 12'h080) + 12'(8 * (c / 4)) + 12'(off);
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic pg_write(input logic [11:0] a, input logic [7:0] v);
        @(negedge clk);
        pg_wr_en = 1'b1; pg_wr_addr = a; pg_wr_data = v;
        @(negedge clk);
        pg_wr_en = 1'b0;
    endtask

    task automatic pg_read(input string r, input logic [11:0] a, input logic [7:0] exp);
        pg_rd_addr = a;
        #1;
        chk(r, 32'(pg_rd_data), 32'(exp));
    endtask

    task automatic strobe(input bit h, input int hc, input bit rl, input int rc);
        @(negedge clk);
        hold_en = h; hold_chan = 3'(hc); rel_en = rl; rel_chan = 3'(rc);
        @(negedge clk);
        hold_en = 1'b0; rel_en = 1'b0;
    endtask

    // predictor: builds the expected grant for each edge from the requirements
    always @(posedge clk) begin
        if (rst_n) begin
            exp_t e;
            logic [7:0] el;
            logic [7:0] md;
            bit f;
            e = '0; f = 1'b0;
            el = mreq & ~mask_i;
            for (int i = 0; i < 8; i++) begin
                int k;
                k = (int'(mptr) + i) % 8;
                if (!f && el[k]) begin
                    f = 1'b1;
                    md = mode_i[k*8 +: 8];
                    e.gnt   = 1'b1;
                    e.chan  = 3'(k);
                    e.addr  = {hp[k][6:0], pg[k], cur_addr_i[k*16 +: 16]};
                    e.len   = (18'(base_cnt_i[k*16 +: 16]) + 18'd1) << (k / 4);
                    e.dir   = md[5];
                    e.unsup = md[5] | (md[7:6] != 2'b01);
                    mptr    = 3'(k + 1);
                end
            end
            sb_q.push_back(e);
            if (hold_en) mreq[hold_chan] = 1'b1;
            if (rel_en)  mreq[rel_chan]  = 1'b0;
        end
    end

    // monitor: compares each cycle's outputs with the queued prediction
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.gnt || grant_o) begin
                n_chk++;
                if (grant_o !== e.gnt ||
                    (e.gnt && (grant_chan_o !== e.chan || grant_addr_o !== e.addr ||
                               grant_len_o !== e.len || grant_dir_o !== e.dir ||
                               grant_unsup_o !== e.unsup))) begin
                    n_fail++;
                    $display("FAIL R3/R5/R6/R8 grant actual=%b ch%0d a=%h l=%h d=%b u=%b expected=%b ch%0d a=%h l=%h d=%b u=%b",
                             grant_o, grant_chan_o, grant_addr_o, grant_len_o, grant_dir_o, grant_unsup_o,
                             e.gnt, e.chan, e.addr, e.len, e.dir, e.unsup);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mreq = '0; mptr = '0;
        for (int c = 0; c < 8; c++) begin
            pg[c] = '0; hp[c] = '0;
            cur_addr_i[c*16 +: 16] = 16'(c * 16'h1111 + 16'h00a5);
            base_cnt_i[c*16 +: 16] = 16'(c * 16'h0010 + 16'h0003);
            mode_i[c*8 +: 8] = 8'h44;
        end
        base_cnt_i[7*16 +: 16] = 16'hFFFF;
        mode_i[7*8 +: 8] = 8'hA8;
        mode_i[6*8 +: 8] = 8'h04;

        repeat (3) @(negedge clk);
        chk("R10 grant after reset", 32'(grant_o), 0);
        chk("R10 err after reset", 32'(pg_err), 0);
        pg_read("R10 page after reset", 12'h087, 8'h00);
        rst_n = 1'b1;

        for (int c = 0; c < 8; c++) begin
            pg_write(port_of(c, 0), 8'(8'h10 + c)); pg[c] = 8'(8'h10 + c);
            pg_write(port_of(c, 1), 8'(8'hA0 + c)); hp[c] = 8'(8'hA0 + c);
        end
        for (int c = 0; c < 8; c++) begin
            pg_read("R1 low page readback", port_of(c, 0), pg[c]);
            pg_read("R2 high page readback", port_of(c, 1), hp[c]);
        end

        pg_write(12'h084, 8'hEE);
        chk("R1 err pulse ctrl0", 32'(pg_err), 1);
        @(negedge clk);
        chk("R1 err single cycle", 32'(pg_err), 0);
        pg_write(12'h48D, 8'hEE);
        chk("R1 err pulse ctrl1 high", 32'(pg_err), 1);
        pg_read("R1 invalid read", 12'h084, 8'h00);
        for (int c = 0; c < 8; c++) begin
            pg_read("R1 no corruption", port_of(c, 0), pg[c]);
        end

        pg_write(12'h489, 8'h5A); hp[6] = 8'h5A;
        chk("R2 no high window err", 32'(nh_err), 0);
        pg_rd_addr = 12'h489; #1;
        chk("R2 disabled high reads 0", 32'(nh_rd_data), 0);
        chk("R2 enabled high readback", 32'(pg_rd_data), 32'h5A);

        @(negedge clk);
        hold_en = 1'b1; hold_chan = 3'd3;
        @(negedge clk);
        hold_en = 1'b0;
        chk("R9 no grant one cycle after hold", 32'(grant_o), 0);
        @(negedge clk);
        chk("R9 grant two cycles after hold", 32'(grant_o), 1);
        chk("R1 grant channel 3", 32'(grant_chan_o), 3);
        strobe(0, 0, 1, 3);
        repeat (2) @(negedge clk);

        strobe(1, 2, 0, 0);
        strobe(1, 5, 0, 0);
        strobe(1, 0, 0, 0);
        repeat (6) @(negedge clk);
        mask_i = 8'b0010_0000;
        repeat (4) @(negedge clk);
        mask_i = 8'b0010_0101;
        @(negedge clk);
        chk("R4 all eligible masked", 32'(grant_o), 0);
        mask_i = 8'h00;
        strobe(0, 0, 1, 0);
        strobe(0, 0, 1, 2);
        strobe(0, 0, 1, 5);
        repeat (3) @(negedge clk);

        strobe(1, 6, 1, 6);
        repeat (2) @(negedge clk);
        chk("R7 release wins tie", 32'(grant_o), 0);

        for (int c = 0; c < 8; c++) strobe(1, c, 0, 0);
        repeat (12) @(negedge clk);
        for (int c = 0; c < 8; c++) strobe(0, 0, 1, c);
        repeat (4) @(negedge clk);
        chk("R7 idle after releases", 32'(grant_o), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule